// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block turns a descriptor table in memory into a series of transfer commands for a bus-master disk DMA data mover. Software places a table of 8-byte entries in memory. Each entry names a buffer and its size. The walker gets the table's base address, the number of bytes the disk command wants moved and a direction bit, and then starts on a one-cycle `start` pulse. It reads one entry at a time through a memory read port. For each buffer it hands the data mover a command of address, length and direction.

The walk ends in one of two ways. Either an entry carries the end-of-table flag, or one 4 KiB page of entries has been read. Entries that come after the requested count is satisfied are still read and added to the total described length, but they produce no command. A table that ends before the requested count is met raises `short_table` in the same cycle as `done`.

The memory request, memory response and command outputs are all valid/ready channels. When a source raises valid, it holds valid and its payload unchanged until the cycle in which ready is also high; a transfer happens on any rising edge where both are high. The walker never has more than one table read outstanding. The data mover may hold `cmd_ready` low for as long as it needs. The memory may hold off a request or delay a response for any number of cycles.

Top module: `prd_walker`

## Requirements
- R1: A table entry arrives as a 64-bit response. Bits [31:0] are the buffer byte address, taken from the lower memory word. Bits [63:32] are the control word.
- R2: The buffer size is control bits [15:1] followed by a zero bit. Control bit 0 has no effect on any command or on the described total.
- R3: A size field of zero in control bits [15:1] stands for 65536 bytes.
- R4: Control bit 31 marks the final entry. After it is used up, no further table read is issued and `done` pulses.
- R5: Table reads go to base, base+8, base+16 and so on. After PAGE_BYTES (4096) bytes of entries, which is 512 reads, the walk ends even if no final flag was seen.
- R6: Each command length is the smaller of the bytes still requested and the bytes left in the current buffer. Command addresses within a buffer advance by the bytes already commanded.
- R7: `described_bytes` reports the sum of the sizes of every entry read in the walk. Entries read after the request is satisfied issue no command.
- R8: `short_table` is high together with `done` exactly when the walk ended with requested bytes still outstanding.
- R9: At most one table read is outstanding. A raised `rd_req_valid` keeps its address until accepted.
- R10: A raised `cmd_valid` keeps its address, length and direction until accepted. `cmd_dir` equals `dir` sampled at start.
- R11: `start` has effect only while `busy` is low. A start clears the segment state and reloads the table pointer from `table_base`. `busy` falls in the cycle after `done`.
- R12: After reset, `busy`, `done`, `short_table`, `rd_req_valid` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (used only when idle) |
| table_base | input | ADDR_W | Byte address of the first table entry |
| req_bytes | input | CNT_W | Bytes the disk command wants moved |
| dir | input | 1 | Transfer direction passed to every command |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| short_table | output | 1 | With `done`: table ended before the request was met |
| described_bytes | output | DSC_W | Total size of all entries read in the walk |
| rd_req_valid | output | 1 | Table read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Byte address of the 8-byte entry |
| rd_rsp_valid | input | 1 | Entry data valid |
| rd_rsp_ready | output | 1 | Walker accepts the entry data |
| rd_rsp_data | input | 64 | Entry: address in [31:0], control in [63:32] |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_addr | output | ADDR_W | Buffer byte address of the chunk |
| cmd_len | output | 17 | Chunk length in bytes, 1 to 65536 |
| cmd_dir | output | 1 | Direction of the chunk |

## Verification
The hardest case to reach from the ports is the page cut-off, because it needs a table with 512 entries and none of them flagged final. The bench's memory model answers every address that has no written entry with a small, unflagged two-byte entry. One walk is started in an untouched region with a request larger than the page can describe. The bench then counts 512 reads, 512 commands and the short flag.

The other subtle point is the tail of a table that follows a satisfied request. It is reached with a request that ends inside the second of three buffers. The expected described total then shows that the third entry was still read.

// File: rtl/prd_pkg.sv
package prd_pkg;

  localparam int SEG_W  = 17;
  localparam int DESC_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH_REQ,
    ST_FETCH_WAIT,
    ST_ISSUE,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic [31:0]      buf_addr;
    logic [SEG_W-1:0] seg_len;
    logic             final_ent;
  } entry_t;

endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode
  import prd_pkg::*;
(
  input  logic [DESC_W-1:0] raw,
  output entry_t            ent
);

  logic [31:0] ctrl_word;
  logic [14:0] half_count;

  always_comb begin
    ctrl_word     = raw[63:32];
    half_count    = ctrl_word[15:1];
    ent.buf_addr  = raw[31:0];
    ent.final_ent = ctrl_word[31];
    if (half_count == 15'd0) begin
      ent.seg_len = 17'h10000;
    end else begin
      ent.seg_len = {1'b0, half_count, 1'b0};
    end
  end

endmodule

// File: rtl/prd_chunk_sel.sv
module prd_chunk_sel
  import prd_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [CNT_W-1:0] want,
  input  logic [SEG_W-1:0] seg_left,
  output logic [SEG_W-1:0] chunk
);

  localparam int PAD_W = CNT_W - SEG_W;

  logic [CNT_W-1:0] seg_wide;

  always_comb begin
    seg_wide = {{PAD_W{1'b0}}, seg_left};
    if (want >= seg_wide) begin
      chunk = seg_left;
    end else begin
      chunk = want[SEG_W-1:0];
    end
  end

endmodule

// File: rtl/prd_table_guard.sv
module prd_table_guard #(
  parameter int PAGE_BYTES = 4096,
  parameter int ENTRY_BYTES = 8,
  parameter int OFF_W = $clog2(PAGE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [OFF_W-1:0] offset,
  output logic             page_full
);

  localparam logic [OFF_W-1:0] LIMIT = OFF_W'(PAGE_BYTES);
  localparam logic [OFF_W-1:0] STEP  = OFF_W'(ENTRY_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
    end else if (clear) begin
      offset <= '0;
    end else if (advance) begin
      offset <= offset + STEP;
    end
  end

  assign page_full = (offset >= LIMIT);

  // walker must never step past the one-page window
  assert_page_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    offset <= LIMIT);

  assert_no_step_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (page_full && !clear) |=> $stable(offset));

endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int PAGE_BYTES = 4096,
  parameter int DSC_W      = $clog2(PAGE_BYTES / 8) + 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] table_base,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic              dir,
  output logic              busy,
  output logic              done,
  output logic              short_table,
  output logic [DSC_W-1:0]  described_bytes,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [63:0]       rd_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [16:0]       cmd_len,
  output logic              cmd_dir
);

  localparam int OFF_W = $clog2(PAGE_BYTES) + 1;

  walk_state_e       state;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  want_q;
  logic              dir_q;
  logic [ADDR_W-1:0] seg_addr_q;
  logic [SEG_W-1:0]  seg_left_q;
  logic              final_q;
  logic [DSC_W-1:0]  total_q;

  entry_t            ent;
  logic [SEG_W-1:0]  chunk;
  logic [OFF_W-1:0]  tbl_off;
  logic              page_full;
  logic              take_start;
  logic              req_fire;
  logic              rsp_fire;
  logic              cmd_fire;

  prd_desc_decode u_decode (
    .raw (rd_rsp_data),
    .ent (ent)
  );

  prd_chunk_sel #(.CNT_W(CNT_W)) u_chunk (
    .want     (want_q),
    .seg_left (seg_left_q),
    .chunk    (chunk)
  );

  prd_table_guard #(
    .PAGE_BYTES  (PAGE_BYTES),
    .ENTRY_BYTES (8),
    .OFF_W       (OFF_W)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (take_start),
    .advance   (req_fire),
    .offset    (tbl_off),
    .page_full (page_full)
  );

  assign take_start = (state == ST_IDLE) && start;
  assign req_fire   = rd_req_valid && rd_req_ready;
  assign rsp_fire   = rd_rsp_valid && rd_rsp_ready;
  assign cmd_fire   = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base_q     <= '0;
      want_q     <= '0;
      dir_q      <= 1'b0;
      seg_addr_q <= '0;
      seg_left_q <= '0;
      final_q    <= 1'b0;
      total_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            base_q     <= table_base;
            want_q     <= req_bytes;
            dir_q      <= dir;
            seg_addr_q <= '0;
            seg_left_q <= '0;
            final_q    <= 1'b0;
            total_q    <= '0;
            state      <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (seg_left_q == '0) begin
            if (final_q || page_full) begin
              state <= ST_DONE;
            end else begin
              state <= ST_FETCH_REQ;
            end
          end else if (want_q != '0) begin
            state <= ST_ISSUE;
          end else begin
            // request satisfied: drop the rest of this buffer
            seg_left_q <= '0;
          end
        end
        ST_FETCH_REQ: begin
          if (rd_req_ready) begin
            state <= ST_FETCH_WAIT;
          end
        end
        ST_FETCH_WAIT: begin
          if (rd_rsp_valid) begin
            seg_addr_q <= ADDR_W'(ent.buf_addr);
            seg_left_q <= ent.seg_len;
            final_q    <= ent.final_ent;
            total_q    <= total_q + DSC_W'(ent.seg_len);
            state      <= ST_CHECK;
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            seg_addr_q <= seg_addr_q + ADDR_W'(chunk);
            seg_left_q <= seg_left_q - chunk;
            want_q     <= want_q - CNT_W'(chunk);
            state      <= ST_CHECK;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (state != ST_IDLE);
  assign done            = (state == ST_DONE);
  assign short_table     = done && (want_q != '0);
  assign described_bytes = total_q;
  assign rd_req_valid    = (state == ST_FETCH_REQ);
  assign rd_req_addr     = base_q + ADDR_W'(tbl_off);
  assign rd_rsp_ready    = (state == ST_FETCH_WAIT);
  assign cmd_valid       = (state == ST_ISSUE);
  assign cmd_addr        = seg_addr_q;
  assign cmd_len         = chunk;
  assign cmd_dir         = dir_q;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !rd_req_valid);

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_dir)));

  assert_cmd_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != 17'd0 && cmd_len <= 17'h10000));

  assert_short_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    short_table |-> done);

  assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_no_cmd_after_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> !cmd_valid);

  assert_total_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take_start && $past(busy)) |-> (described_bytes >= $past(described_bytes)));

endmodule

// File: tb/sim_prd_walker.sv
module sim_prd_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] table_base = '0;
  logic [23:0] req_bytes = '0;
  logic        dir = 1'b0;
  logic        busy, done, short_table;
  logic [25:0] described_bytes;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [63:0] rd_rsp_data = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_addr;
  logic [16:0] cmd_len;
  logic        cmd_dir;

  always #10 clk = ~clk;

  prd_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
    .req_bytes(req_bytes), .dir(dir), .busy(busy), .done(done),
    .short_table(short_table), .described_bytes(described_bytes),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_dir(cmd_dir)
  );

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int cycles = 0;
  logic [31:0] walk_base = '0;
  logic [63:0] mem [logic [31:0]];
  logic [49:0] expq [$];

  function automatic logic [63:0] entry_at(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {32'h0000_0002, a};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // memory responder plus read-order checks (R5, R9)
  logic        pend = 1'b0;
  logic        drop = 1'b0;
  logic [31:0] paddr = '0;
  int          dly = 0;
  always @(negedge clk) begin
    if (drop) begin rd_rsp_valid = 1'b0; drop = 1'b0; end
    if (pend) begin
      if (dly == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = entry_at(paddr);
        pend = 1'b0;
      end else dly--;
    end
    if (rd_req_valid && (pend || rd_rsp_valid))
      check(1'b0, "R9 read while outstanding", 1, 0);
    rd_req_ready = ($urandom % 4) != 0;
    if (rd_req_valid && rd_req_ready) begin
      check(rd_req_addr == walk_base + 32'(reads * 8), "R5 read address",
            rd_req_addr, walk_base + 32'(reads * 8));
      reads++;
      pend  = 1'b1;
      paddr = rd_req_addr;
      dly   = $urandom % 3;
    end
    if (rd_rsp_valid && rd_rsp_ready) drop = 1'b1;
  end

  // scoreboard monitor for commands (R6, R10)
  always @(negedge clk) begin
    cmd_ready = ($urandom % 3) != 0;
    if (cmd_valid && cmd_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected command", {cmd_dir, cmd_addr, cmd_len}, 0);
      end else begin
        logic [49:0] e;
        e = expq.pop_front();
        check({cmd_dir, cmd_addr, cmd_len} == e, "R6/R10 command",
              {cmd_dir, cmd_addr, cmd_len}, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // driver: compute expectations, push them, then run one walk
  task automatic run_case(input string tag, input logic [31:0] base,
                          input logic [23:0] want, input logic d, input bit mid_start);
    longint rem = want;
    longint tot = 0;
    int     nrd = 0;
    for (int k = 0; k < 512; k++) begin
      logic [63:0] w;
      longint ln;
      w  = entry_at(base + 32'(k * 8));
      ln = (w[47:33] == 0) ? 65536 : {w[47:33], 1'b0};
      tot += ln;
      nrd++;
      if (rem > 0) begin
        longint c;
        c = (rem < ln) ? rem : ln;
        expq.push_back({d, w[31:0], 17'(c)});
        rem -= c;
      end
      if (w[63]) break;
    end
    reads = 0;
    walk_base = base;
    @(negedge clk);
    table_base = base; req_bytes = want; dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (3) @(negedge clk);
      table_base = base + 32'h40; req_bytes = 24'd5; dir = ~d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(short_table == (rem > 0), {tag, " R8 short flag"}, short_table, rem > 0);
    check(described_bytes == tot, {tag, " R7 described"}, described_bytes, tot);
    check(reads == nrd, {tag, " R4/R5 read count"}, reads, nrd);
    check(expq.size() == 0, {tag, " R6 commands left"}, expq.size(), 0);
    @(negedge clk);
    check(!busy, {tag, " R11 idle after done"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !short_table && !rd_req_valid && !cmd_valid,
          "R12 reset outputs", {busy, done, short_table, rd_req_valid, cmd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R12 idle after reset", busy, 0);

    // R1: single final entry, exact size
    mem[32'h1000] = {32'h8000_0100, 32'hA000_0000};
    run_case("R1", 32'h1000, 24'h100, 1'b0, 1'b0);
    // R2: bit 0 of size is ignored; short table
    mem[32'h2000] = {32'h8000_0101, 32'hB000_0010};
    run_case("R2", 32'h2000, 24'h1000, 1'b1, 1'b0);
    // R3: zero size means 65536
    mem[32'h3000] = {32'h8000_0000, 32'hC000_0000};
    run_case("R3", 32'h3000, 24'h20000, 1'b0, 1'b0);
    // R7: request ends mid second buffer; third entry still read
    mem[32'h4000] = {32'h0000_0200, 32'hD000_0000};
    mem[32'h4008] = {32'h0000_0200, 32'hD100_0000};
    mem[32'h4010] = {32'h8000_0200, 32'hD200_0000};
    run_case("R7", 32'h4000, 24'h300, 1'b1, 1'b0);
    // R6: zero request gives no commands
    run_case("R6", 32'h4000, 24'h0, 1'b0, 1'b0);
    // R4: final flag on second entry stops before the default region
    mem[32'h5000] = {32'h0000_0010, 32'hE000_0000};
    mem[32'h5008] = {32'h8000_0020, 32'hE100_0000};
    run_case("R4", 32'h5000, 24'h25, 1'b0, 1'b0);
    // R11: start during a walk is ignored
    run_case("R11", 32'h4000, 24'h301, 1'b0, 1'b1);
    // R5: page cut-off with no final flag
    run_case("R5", 32'h0010_0000, 24'd2000, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule